// File: doc/BRIEF.md
# Time-Stepped Boolean Lookup-Table Array

This block is a small array of boolean processing elements for a logic-emulation engine. A netlist is first reduced to 3-input gates. The gates are then spread over the elements and over a sequence of time steps. In each step, every element runs one instruction from its own local instruction memory. The instruction either evaluates a 3-input function given by an 8-bit truth table, or makes the element behave as a one-bit storage cell.

Each element drives one bit of a shared broadcast bus. The bus holds the values registered at the end of the previous step. Every element picks its three inputs from that bus, so the order in which elements are evaluated within a step has no effect on the result.

A step counter walks through the instruction memories while `run` is high. It wraps to step 0 after a programmable last index, and it flags each completed pass with a one-cycle pulse. The instruction memories are written through a simple write port while the array is stopped.

Top module: `lut_emu_array`

## Requirements
- R1: After reset, `bus_out` is all zero, `step_idx` is 0 and `cycle_done` is 0. Every instruction word resets to zero, which means logic mode with an all-zero table.
- R2: An instruction word is laid out as follows.
  - Bit 0 is the mode: 0 for logic, 1 for memory.
  - Bits [3:1] select input a, bits [6:4] select input b and bits [9:7] select input c. Each selector is an index into the bus.
  - Bits [17:10] hold the truth table.
  - In logic mode, the element's bus bit after the step equals table bit {c,b,a}, with a as the least significant bit of that index.
- R3: All elements read the bus as it stood before the step. For example, two elements that each copy the other exchange their values in a single step.
- R4: In memory mode, input b is the write enable and input a is the write data.
  - When b is 1, the stored bit takes a.
  - When b is 0, the stored bit keeps its value.
  - In both cases the element's bus bit after the step is the stored bit's new value.
- R5: Steps in logic mode leave an element's stored bit untouched. A later memory-mode step with the enable at 0 shows the value written before those steps.
- R6: On each clock with `run` high, `step_idx` advances by one. After the step whose index equals `last_step`, it returns to 0.
- R7: `cycle_done` is high for exactly the one cycle that follows a run clock executing step `last_step`. It is low at all other times.
- R8: While `run` is low, `bus_out`, `step_idx` and every stored bit hold their values.
- R9: A clock with `prog_we` high writes `prog_data` into address `prog_addr` of element `prog_pe`. Steps executed after that write use the new instruction.
- R10: With `last_step` at 0, every run clock executes step 0, and `cycle_done` stays high while `run` is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Execute one step per clock while high |
| last_step | input | STEP_W (4) | Index of the final step before wrapping |
| prog_we | input | 1 | Instruction write strobe |
| prog_pe | input | SEL_W (3) | Element whose instruction memory is written |
| prog_addr | input | STEP_W (4) | Instruction address to write |
| prog_data | input | INSTR_W (18) | Instruction word to write |
| bus_out | output | NUM_PE (8) | Broadcast bus: one registered bit per element |
| step_idx | output | STEP_W (4) | Index of the next step to execute |
| cycle_done | output | 1 | One-cycle pulse after the last step of a pass |

## Verification
The bench targets the following corner cases:
- **Swap of two elements in one step.** A design that let an element see a value produced in the same step would copy one value into both positions instead of exchanging them.
- **Memory cells across logic-mode steps.** The bench drives different values onto the bus while the cells are in logic mode, then reads them back with the enable off. A design that wrote the stored bit from the logic result, or that showed the old stored value instead of the value just written, would show the wrong bits.
- **Run pauses partway through a pass.** A counter or cell that kept moving while stopped would shift every later step.
- **A last index of zero.** A counter that wrapped one step late, or a done pulse that did not repeat, would show a nonzero step index or a missing pulse.

// File: rtl/lut_emu_pkg.sv
package lut_emu_pkg;

  // Width of one truth table; a 3-input function has 8 rows.
  localparam int unsigned TBL_W  = 8;
  localparam int unsigned LUT_IN = 3;

  typedef enum logic {
    MODE_LOGIC = 1'b0,
    MODE_MEM   = 1'b1
  } pe_mode_e;

  // Row lookup: the gathered input bits form the row number.
  function automatic logic lut_pick(input logic [TBL_W-1:0] tbl,
                                    input logic [LUT_IN-1:0] row);
    return tbl[row];
  endfunction

  // Storage update: write data when enabled, otherwise keep the held bit.
  function automatic logic cell_next(input logic held, input logic wen,
                                     input logic wdat);
    return wen ? wdat : held;
  endfunction

endpackage

// File: rtl/lut_emu_imem.sv
module lut_emu_imem #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 18,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= '0;
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/lut_emu_cell.sv
module lut_emu_cell
  import lut_emu_pkg::*;
#(
  parameter int NUM_PE  = 8,
  parameter int SEL_W   = 3,
  parameter int INSTR_W = 1 + 3*SEL_W + 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step_en,
  input  logic [INSTR_W-1:0] instr,
  input  logic [NUM_PE-1:0]  bus_in,
  output logic               bit_q,
  output logic               wr_evt,
  output logic               wr_val
);

  // Field positions inside the instruction word
  localparam int A_LO = 1;
  localparam int B_LO = A_LO + SEL_W;
  localparam int C_LO = B_LO + SEL_W;
  localparam int T_LO = C_LO + SEL_W;

  pe_mode_e          mode;
  logic [SEL_W-1:0]  sel_a, sel_b, sel_c;
  logic [TBL_W-1:0]  tbl;
  logic              in_a, in_b, in_c;
  logic              lut_bit;
  logic              store_q;
  logic              store_nx;
  logic              out_nx;

  assign mode  = pe_mode_e'(instr[0]);
  assign sel_a = instr[A_LO +: SEL_W];
  assign sel_b = instr[B_LO +: SEL_W];
  assign sel_c = instr[C_LO +: SEL_W];
  assign tbl   = instr[T_LO +: TBL_W];

  assign in_a = bus_in[sel_a];
  assign in_b = bus_in[sel_b];
  assign in_c = bus_in[sel_c];

  assign lut_bit  = lut_pick(tbl, {in_c, in_b, in_a});
  assign store_nx = cell_next(store_q, (mode == MODE_MEM) && in_b, in_a);
  assign out_nx   = (mode == MODE_MEM) ? store_nx : lut_bit;

  // Events brought out for the checker
  assign wr_evt = step_en && (mode == MODE_MEM) && in_b;
  assign wr_val = in_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q   <= 1'b0;
      store_q <= 1'b0;
    end else if (step_en) begin
      bit_q   <= out_nx;
      store_q <= store_nx;
    end
  end

endmodule

// File: rtl/lut_emu_seq.sv
module lut_emu_seq #(
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [STEP_W-1:0] last_step,
  output logic [STEP_W-1:0] step_q,
  output logic              done_q,
  output logic              wrap_evt
);

  assign wrap_evt = run && (step_q == last_step);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wrap_evt;
      if (run) step_q <= wrap_evt ? '0 : step_q + 1'b1;
    end
  end

endmodule

// File: rtl/lut_emu_array.sv
module lut_emu_array #(
  parameter int NUM_PE  = 8,
  parameter int DEPTH   = 16,
  parameter int SEL_W   = $clog2(NUM_PE),
  parameter int STEP_W  = $clog2(DEPTH),
  parameter int INSTR_W = 1 + 3*SEL_W + 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic [STEP_W-1:0]  last_step,
  input  logic               prog_we,
  input  logic [SEL_W-1:0]   prog_pe,
  input  logic [STEP_W-1:0]  prog_addr,
  input  logic [INSTR_W-1:0] prog_data,
  output logic [NUM_PE-1:0]  bus_out,
  output logic [STEP_W-1:0]  step_idx,
  output logic               cycle_done
);

  logic [STEP_W-1:0] step_q;
  logic              wrap_evt;
  logic [NUM_PE-1:0] bus_q;
  logic [NUM_PE-1:0] mem_wr;
  logic [NUM_PE-1:0] mem_wval;

  lut_emu_seq #(.STEP_W(STEP_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run),
    .last_step (last_step),
    .step_q    (step_q),
    .done_q    (cycle_done),
    .wrap_evt  (wrap_evt)
  );

  for (genvar g = 0; g < NUM_PE; g++) begin : g_pe
    logic [INSTR_W-1:0] instr;
    logic               wr_sel;

    assign wr_sel = prog_we && (prog_pe == SEL_W'(g));

    lut_emu_imem #(.DEPTH(DEPTH), .WIDTH(INSTR_W), .AW(STEP_W)) u_imem (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_sel),
      .wr_addr (prog_addr),
      .wr_data (prog_data),
      .rd_addr (step_q),
      .rd_data (instr)
    );

    lut_emu_cell #(.NUM_PE(NUM_PE), .SEL_W(SEL_W), .INSTR_W(INSTR_W)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (run),
      .instr   (instr),
      .bus_in  (bus_q),
      .bit_q   (bus_q[g]),
      .wr_evt  (mem_wr[g]),
      .wr_val  (mem_wval[g])
    );
  end

  assign bus_out  = bus_q;
  assign step_idx = step_q;

endmodule

// File: rtl/lut_emu_array_chk.sv
module lut_emu_array_chk #(
  parameter int NUM_PE = 8,
  parameter int STEP_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [STEP_W-1:0] last_step,
  input logic [STEP_W-1:0] step_idx,
  input logic              cycle_done,
  input logic [NUM_PE-1:0] bus_out,
  input logic              wrap_evt,
  input logic [NUM_PE-1:0] mem_wr,
  input logic [NUM_PE-1:0] mem_wval
);

  // R6
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_idx == last_step) |=> (step_idx == '0));

  // R6
  step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step_idx != last_step) |=>
      (step_idx == $past(step_idx) + {{(STEP_W-1){1'b0}}, 1'b1}));

  // R7
  done_after_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> cycle_done);

  // R7
  done_only_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> !cycle_done);

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ($stable(bus_out) && $stable(step_idx)));

  for (genvar i = 0; i < NUM_PE; i++) begin : g_mw
    // R4
    mem_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr[i] |=> (bus_out[i] == $past(mem_wval[i])));
  end

endmodule

bind lut_emu_array lut_emu_array_chk #(.NUM_PE(NUM_PE), .STEP_W(STEP_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .last_step  (last_step),
  .step_idx   (step_idx),
  .cycle_done (cycle_done),
  .bus_out    (bus_out),
  .wrap_evt   (wrap_evt),
  .mem_wr     (mem_wr),
  .mem_wval   (mem_wval)
);

// File: tb/lut_emu_array_bench.sv
module lut_emu_array_bench;

  localparam int N  = 8;
  localparam int D  = 16;
  localparam int SW = 3;
  localparam int TW = 4;
  localparam int IW = 18;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic [TW-1:0] last_step = '0;
  logic          prog_we = 1'b0;
  logic [SW-1:0] prog_pe = '0;
  logic [TW-1:0] prog_addr = '0;
  logic [IW-1:0] prog_data = '0;
  wire  [N-1:0]  bus_out;
  wire  [TW-1:0] step_idx;
  wire           cycle_done;

  lut_emu_array u_lut_emu_array (
    .clk(clk), .rst_n(rst_n), .run(run), .last_step(last_step),
    .prog_we(prog_we), .prog_pe(prog_pe), .prog_addr(prog_addr),
    .prog_data(prog_data), .bus_out(bus_out), .step_idx(step_idx),
    .cycle_done(cycle_done)
  );

  typedef struct {
    int            cyc;
    logic [N-1:0]  bus;
    logic [TW-1:0] step;
    logic          done;
    string         tag;
  } exp_t;

  exp_t q[$];
  int   cyc_cnt = 0;
  int   vectors = 0;
  int   miscmp  = 0;

  always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

  // Shadow of the programmed instructions
  bit       sh_mem [N][D];
  int       sh_a   [N][D];
  int       sh_b   [N][D];
  int       sh_c   [N][D];
  bit [7:0] sh_tbl [N][D];

  // Reference state
  bit [N-1:0] m_bus   = '0;
  bit [N-1:0] m_store = '0;
  int         m_step  = 0;

  task automatic check(input string tag, input string what,
                       input int act, input int exp);
    vectors++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic ld(input int pe, input int a, input bit mode, input int sa,
                    input int sb, input int sc, input bit [7:0] tbl);
    @(negedge clk);
    sh_mem[pe][a] = mode; sh_a[pe][a] = sa; sh_b[pe][a] = sb;
    sh_c[pe][a] = sc; sh_tbl[pe][a] = tbl;
    prog_pe   = SW'(pe);
    prog_addr = TW'(a);
    prog_data = {tbl, SW'(sc), SW'(sb), SW'(sa), mode};
    prog_we   = 1'b1;
    @(negedge clk);
    prog_we   = 1'b0;
  endtask

  task automatic kst(input int pe, input int a, input bit [7:0] tbl);
    ld(pe, a, 1'b0, 0, 0, 0, tbl);
  endtask

  // Driver: one clock, pushes the expected result of that clock
  task automatic step_once(input bit en, input string tag);
    exp_t       e;
    bit [N-1:0] nb;
    bit [N-1:0] ns;
    int         row;
    @(negedge clk);
    run = en;
    e.done = 1'b0;
    if (en) begin
      nb = m_bus; ns = m_store;
      for (int p = 0; p < N; p++) begin
        if (sh_mem[p][m_step]) begin
          if (m_bus[sh_b[p][m_step]]) ns[p] = m_bus[sh_a[p][m_step]];
          nb[p] = ns[p];
        end else begin
          row = 4*m_bus[sh_c[p][m_step]] + 2*m_bus[sh_b[p][m_step]]
              + m_bus[sh_a[p][m_step]];
          nb[p] = (sh_tbl[p][m_step] >> row) & 8'h01;
        end
      end
      e.done = (m_step == int'(last_step));
      m_step = e.done ? 0 : m_step + 1;
      m_bus = nb; m_store = ns;
    end
    e.cyc = cyc_cnt + 1; e.bus = m_bus; e.step = TW'(m_step); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_drain();
    @(negedge clk); run = 1'b0;
    @(negedge clk); @(negedge clk);
  endtask

  // Monitor: compares at the falling edge after each expected clock
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].cyc == cyc_cnt) begin
        e = q.pop_front();
        check(e.tag, "bus_out", int'(bus_out), int'(e.bus));
        check(e.tag, "step_idx", int'(step_idx), int'(e.step));
        check(e.tag, "cycle_done", int'(cycle_done), int'(e.done));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "bus_out", int'(bus_out), 0);
    check("R1", "step_idx", int'(step_idx), 0);
    check("R1", "cycle_done", int'(cycle_done), 0);
    // R1 zeroed instruction memory: one run step yields all-zero bus
    last_step = 4'd3;
    step_once(1'b1, "R1 R2");
    idle_drain();
    step_once(1'b1, "R1"); step_once(1'b1, "R1"); step_once(1'b1, "R6");
    idle_drain();

    // Scenario A: logic mode, swap, wrap (R2 R3 R6 R7 R9)
    for (int p = 0; p < N; p++) begin
      kst(p, 0, (p % 2 == 0) ? 8'hFF : 8'h00);
      ld(p, 1, 1'b0, p, p, p, 8'h55);
      if (p == 0)      ld(p, 2, 1'b0, 1, 1, 1, 8'hAA);
      else if (p == 1) ld(p, 2, 1'b0, 0, 0, 0, 8'hAA);
      else             ld(p, 2, 1'b0, p-1, p, (p+1) % N, 8'h96);
      if (p == 0)      ld(p, 3, 1'b0, 1, 2, 3, 8'h80);
      else             ld(p, 3, 1'b0, p, (p+1) % N, (p+2) % N, 8'hE8);
    end
    for (int s = 0; s < 8; s++) step_once(1'b1, "R2 R3 R6 R7 R9");
    idle_drain();

    // Scenario B: memory cells (R4 R5 R8 R9), last index 4
    last_step = 4'd4;
    kst(0, 0, 8'hFF); kst(1, 0, 8'hFF); kst(2, 0, 8'h00);
    kst(5, 0, 8'hFF); kst(6, 0, 8'h00); kst(7, 0, 8'h00);
    ld(3, 0, 1'b1, 6, 2, 0, 8'h00);
    ld(4, 0, 1'b1, 6, 7, 0, 8'h00);
    kst(0, 1, 8'h00); kst(1, 1, 8'h00); kst(2, 1, 8'hFF);
    kst(5, 1, 8'hFF); kst(6, 1, 8'hFF); kst(7, 1, 8'h00);
    ld(3, 1, 1'b1, 2, 1, 0, 8'h00);
    ld(4, 1, 1'b1, 0, 0, 0, 8'h00);
    for (int a = 2; a <= 4; a++) begin
      kst(2, a, 8'hFF); kst(5, a, 8'hFF); kst(7, a, 8'h00);
      ld(0, a, 1'b0, 3, 3, 3, 8'hAA);
      ld(1, a, 1'b0, 4, 4, 4, 8'hAA);
      ld(6, a, 1'b0, 3, 4, 4, 8'h66);
    end
    kst(3, 2, 8'hFF);
    kst(4, 2, 8'h00);
    ld(3, 3, 1'b1, 0, 7, 0, 8'h00);
    ld(4, 3, 1'b1, 0, 7, 0, 8'h00);
    ld(3, 4, 1'b1, 2, 2, 0, 8'h00);
    ld(4, 4, 1'b1, 7, 5, 0, 8'h00);
    for (int s = 0; s < 6; s++) step_once(1'b1, "R4 R5 R9");
    for (int s = 0; s < 3; s++) step_once(1'b0, "R8");
    for (int s = 0; s < 4; s++) step_once(1'b1, "R4 R5 R7");
    idle_drain();

    // Scenario C: single-step pass (R10)
    last_step = 4'd0;
    for (int s = 0; s < 4; s++) step_once(1'b1, "R10");
    idle_drain();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule